// File: doc/BRIEF.md
# Ethernet Pause Flow Control Trigger

This block decides when a MAC should send an IEEE 802.3x pause frame. It watches the free space left in the receive buffer, counted in kilobytes, against two programmable water marks. When the space first drops below the high mark, it requests a pause with the maximum time (FFFFh). Once that frame has gone out, the block arms a release. When the space then climbs above the low mark, it requests a pause with zero time. Software can also ask for a single zero-time or maximum-time pause through two command bits. Each command bit clears itself when the transmit path reports that the frame is done.

Toward the transmit path the block offers one request at a time. The request carries the pause time and stays up until the transmit path acknowledges completion. The block also records received pause frames for software, and it gates a transmit-halt output with a flow-control enable bit. In half duplex it can raise a jam pulse for back-pressure. One mode jams on any arriving packet and the other jams only on a destination-address match. Either way, the jam fires only while buffer occupancy is above a third threshold.

Register map. Address 0 holds the high mark in bits 7:4 (reset 3) and the low mark in bits 3:0 (reset 8). Address 1 is the control register. Address 2 holds the back-pressure occupancy threshold in bits 3:0 (reset 12). Address 3 reads zero.

Control register bits:

| Bit | Access | Function |
|-----|--------|----------|
| 0 | write | manual zero-time command |
| 1 | write | manual maximum-time command |
| 2 | write | automatic enable |
| 3 | write | flow-control enable |
| 4 | write | jam on any packet |
| 5 | write | jam on address match |
| 6 | read, cleared by the read | received-pause seen |
| 7 | read-only | current receive pause state |

Occupancy is the buffer size (16 KB by default) minus the free space.

Top module: `pause_flow_trigger`

## Requirements
- R1: After reset, address 0 reads 38h, address 1 reads 00h, address 2 reads 0Ch, and txReq and jamReq are low.
- R2: With automatic enable set and the block idle, free space first falling below a nonzero high mark raises txReq with time FFFFh two clock edges later.
- R3: A high mark of zero raises the maximum-time request only when free space equals zero.
- R4: A zero-time request is raised when free space exceeds the low mark, but only after the maximum-time pause has been acknowledged. Without that prior pause, high free space requests nothing.
- R5: After the maximum-time pause is acknowledged, space that stays or falls below the high mark raises nothing more. After the zero-time pause is acknowledged, a new maximum-time pause needs a fresh fall below the high mark.
- R6: With automatic enable clear, threshold crossings raise no request.
- R7: Writing control bit 0 or bit 1 raises one request: bit 0 gives time 0000h and bit 1 gives FFFFh. The bit reads back set until txDone, and then it reads zero.
- R8: Only one request is outstanding. It stays high with a stable time until txDone. When a manual and an automatic request are pending in the same cycle, the manual one is sent first.
- R9: A received-pause pulse sets control bit 6. A read of address 1 clears it, and a pulse in the same cycle as the read wins. Bit 7 follows rxPauseActive.
- R10: txHalt is high only when rxPauseActive and the flow-control enable (control bit 3) are both set.
- R11: In half duplex, a packet start raises jamReq for one cycle on the next edge when occupancy exceeds the back-pressure threshold. This happens in any-packet mode (bit 4), or in address mode (bit 5) with rxDaMatch set. In full duplex jamReq stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| regWrEn | input | 1 | register write strobe |
| regRdEn | input | 1 | register read strobe (drives read-clear) |
| regAddr | input | 2 | register address |
| regWrData | input | 8 | write data |
| regRdData | output | 8 | read data for regAddr |
| freeKb | input | FREE_W (5) | receive buffer free space in KB |
| txReq | output | 1 | pause frame request to the transmit path |
| txPauseTime | output | 16 | pause time carried with txReq |
| txDone | input | 1 | pause frame transmission complete |
| rxPauseValid | input | 1 | pulse: a pause frame was received |
| rxPauseActive | input | 1 | receive pause timer currently running |
| txHalt | output | 1 | stall request to the transmitter |
| halfDuplex | input | 1 | link is half duplex |
| rxPktStart | input | 1 | pulse: a receive packet begins |
| rxDaMatch | input | 1 | that packet's destination address matched |
| jamReq | output | 1 | one-cycle jam request for back-pressure |

## Verification
The arbiter can see a manual command and a fresh high-water crossing in the same cycle. The bench provokes this by writing the zero-time command while lowering free space on the same edge with automatic enable already set. It then checks that the zero-time frame goes first and stays held, and that the maximum-time frame follows on the edge after its acknowledge. The received-pause latch can also be set and cleared together: a pause pulse landing on a read of the control register must leave the status bit set.

// File: rtl/pft_pkg.sv
package pft_pkg;

  typedef enum logic [1:0] {
    KIND_MAN_XON,
    KIND_MAN_XOFF,
    KIND_AUTO_XOFF,
    KIND_AUTO_XON
  } pauseKind_e;

  typedef enum logic {
    HYS_IDLE,
    HYS_ARMED
  } hysState_e;

  // strobes from control toward the datapath
  typedef struct packed {
    logic clrManXon;
    logic clrManXoff;
  } ctrlStrobe_t;

  // configuration seen by control
  typedef struct packed {
    logic manXon;
    logic manXoff;
    logic autoEn;
  } cfgView_t;

endpackage

// File: rtl/pft_datapath.sv
module pft_datapath
  import pft_pkg::*;
#(
  parameter int BUF_KB   = 16,
  parameter int FREE_W   = 5,
  parameter int THR_W    = 4,
  parameter int HI_RESET = 3,
  parameter int LO_RESET = 8,
  parameter int BP_RESET = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [FREE_W-1:0] freeKb,
  input  logic              halfDuplex,
  input  logic              rxPktStart,
  input  logic              rxDaMatch,
  input  logic              rxPauseValid,
  input  logic              rxPauseActive,
  input  ctrlStrobe_t       strobe,
  output cfgView_t          cfg,
  output logic              belowHigh,
  output logic              aboveLow,
  output logic              jamReq,
  output logic              txHalt
);

  localparam logic [1:0] ADDR_THR  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_BP   = 2'd2;

  logic [THR_W-1:0] hiThr, loThr, bpThr;
  logic manXon, manXoff, autoEn, flowEn, jamAny, jamMatch, rxSeen;
  logic ctrlWr, ctrlRd;
  logic [FREE_W-1:0] occKb;
  logic jamHit;

  assign ctrlWr = regWrEn && regAddr == ADDR_CTRL;
  assign ctrlRd = regRdEn && regAddr == ADDR_CTRL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiThr    <= THR_W'(HI_RESET);
      loThr    <= THR_W'(LO_RESET);
      bpThr    <= THR_W'(BP_RESET);
      manXon   <= 1'b0;
      manXoff  <= 1'b0;
      autoEn   <= 1'b0;
      flowEn   <= 1'b0;
      jamAny   <= 1'b0;
      jamMatch <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_THR) begin
        hiThr <= regWrData[7:4];
        loThr <= regWrData[3:0];
      end
      if (regWrEn && regAddr == ADDR_BP) bpThr <= regWrData[3:0];
      if (ctrlWr) begin
        manXon   <= regWrData[0];
        manXoff  <= regWrData[1];
        autoEn   <= regWrData[2];
        flowEn   <= regWrData[3];
        jamAny   <= regWrData[4];
        jamMatch <= regWrData[5];
      end else begin
        if (strobe.clrManXon)  manXon  <= 1'b0;
        if (strobe.clrManXoff) manXoff <= 1'b0;
      end
    end
  end

  // received-pause latch: a new pulse wins over the read-clear
  always_ff @(posedge clk) begin
    if (!rstN)             rxSeen <= 1'b0;
    else if (rxPauseValid) rxSeen <= 1'b1;
    else if (ctrlRd)       rxSeen <= 1'b0;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_THR:  regRdData = {hiThr, loThr};
      ADDR_CTRL: regRdData = {rxPauseActive, rxSeen, jamMatch, jamAny,
                              flowEn, autoEn, manXoff, manXon};
      ADDR_BP:   regRdData = {4'h0, bpThr};
      default:   regRdData = 8'h00;
    endcase
  end

  // water-mark comparisons
  always_comb begin
    if (hiThr == '0) belowHigh = (freeKb == '0);
    else             belowHigh = int'(freeKb) < int'(hiThr);
    aboveLow = int'(freeKb) > int'(loThr);
  end

  assign cfg    = '{manXon: manXon, manXoff: manXoff, autoEn: autoEn};
  assign txHalt = flowEn && rxPauseActive;

  // back-pressure jam
  assign occKb  = (int'(freeKb) > BUF_KB) ? '0 : FREE_W'(BUF_KB) - freeKb;
  assign jamHit = halfDuplex && rxPktStart && (int'(occKb) > int'(bpThr)) &&
                  (jamAny || (jamMatch && rxDaMatch));

  always_ff @(posedge clk) begin
    if (!rstN) jamReq <= 1'b0;
    else       jamReq <= jamHit;
  end

  a_r9_seen_latch: assert property (@(posedge clk) disable iff (!rstN)
    rxPauseValid |=> rxSeen);

  a_r11_jam_half_only: assert property (@(posedge clk) disable iff (!rstN)
    jamReq |-> $past(halfDuplex) && $past(rxPktStart));

  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrManXon && !ctrlWr |=> !manXon);

endmodule

// File: rtl/pft_ctrl.sv
module pft_ctrl
  import pft_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgView_t          cfg,
  input  logic              belowHigh,
  input  logic              aboveLow,
  input  logic              txDone,
  output logic              txReq,
  output logic [TIME_W-1:0] txPauseTime,
  output ctrlStrobe_t       strobe
);

  localparam logic [TIME_W-1:0] TIME_MAX  = '1;
  localparam logic [TIME_W-1:0] TIME_ZERO = '0;

  hysState_e  hys;
  pauseKind_e curKind, nextKind;
  logic       belowPrev, pendXoff, launch, done, fresh;

  assign fresh = belowHigh && !belowPrev;
  assign done  = txReq && txDone;

  // selection: manual before automatic, one request at a time
  always_comb begin
    launch   = 1'b0;
    nextKind = KIND_MAN_XON;
    if (!txReq) begin
      if (cfg.manXon) begin
        launch = 1'b1; nextKind = KIND_MAN_XON;
      end else if (cfg.manXoff) begin
        launch = 1'b1; nextKind = KIND_MAN_XOFF;
      end else if (pendXoff) begin
        launch = 1'b1; nextKind = KIND_AUTO_XOFF;
      end else if (hys == HYS_ARMED && cfg.autoEn && aboveLow) begin
        launch = 1'b1; nextKind = KIND_AUTO_XON;
      end
    end
  end

  always_comb begin
    strobe.clrManXon  = done && curKind == KIND_MAN_XON;
    strobe.clrManXoff = done && curKind == KIND_MAN_XOFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      belowPrev   <= 1'b0;
      pendXoff    <= 1'b0;
      hys         <= HYS_IDLE;
      txReq       <= 1'b0;
      curKind     <= KIND_MAN_XON;
      txPauseTime <= TIME_ZERO;
    end else begin
      belowPrev <= belowHigh;

      if (!cfg.autoEn)
        pendXoff <= 1'b0;
      else if (launch && nextKind == KIND_AUTO_XOFF)
        pendXoff <= 1'b0;
      else if (fresh && hys == HYS_IDLE &&
               !(txReq && curKind == KIND_AUTO_XOFF))
        pendXoff <= 1'b1;

      if (done) begin
        txReq <= 1'b0;
        if (curKind == KIND_AUTO_XOFF) hys <= HYS_ARMED;
        if (curKind == KIND_AUTO_XON)  hys <= HYS_IDLE;
      end else if (launch) begin
        txReq   <= 1'b1;
        curKind <= nextKind;
        txPauseTime <= (nextKind == KIND_MAN_XOFF || nextKind == KIND_AUTO_XOFF)
                       ? TIME_MAX : TIME_ZERO;
      end
    end
  end

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txDone |=> txReq && $stable(txPauseTime));

  a_r4_xon_armed: assert property (@(posedge clk) disable iff (!rstN)
    txReq && curKind == KIND_AUTO_XON |-> hys == HYS_ARMED);

  a_r5_idle_after_xon: assert property (@(posedge clk) disable iff (!rstN)
    txReq && txDone && curKind == KIND_AUTO_XON |=> hys == HYS_IDLE);

endmodule

// File: rtl/pause_flow_trigger.sv
module pause_flow_trigger
  import pft_pkg::*;
#(
  parameter int BUF_KB = 16,
  parameter int TIME_W = 16,
  localparam int FREE_W = $clog2(BUF_KB + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [FREE_W-1:0] freeKb,
  output logic              txReq,
  output logic [TIME_W-1:0] txPauseTime,
  input  logic              txDone,
  input  logic              rxPauseValid,
  input  logic              rxPauseActive,
  output logic              txHalt,
  input  logic              halfDuplex,
  input  logic              rxPktStart,
  input  logic              rxDaMatch,
  output logic              jamReq
);

  ctrlStrobe_t strobe;
  cfgView_t    cfg;
  logic        belowHigh, aboveLow;

  pft_datapath #(
    .BUF_KB(BUF_KB), .FREE_W(FREE_W), .THR_W(4),
    .HI_RESET(3), .LO_RESET(8), .BP_RESET(12)
  ) datapath_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .freeKb(freeKb), .halfDuplex(halfDuplex), .rxPktStart(rxPktStart),
    .rxDaMatch(rxDaMatch), .rxPauseValid(rxPauseValid),
    .rxPauseActive(rxPauseActive), .strobe(strobe), .cfg(cfg),
    .belowHigh(belowHigh), .aboveLow(aboveLow),
    .jamReq(jamReq), .txHalt(txHalt)
  );

  pft_ctrl #(.TIME_W(TIME_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .belowHigh(belowHigh), .aboveLow(aboveLow),
    .txDone(txDone), .txReq(txReq), .txPauseTime(txPauseTime),
    .strobe(strobe)
  );

  a_r10_halt_needs_pause: assert property (@(posedge clk) disable iff (!rstN)
    txHalt |-> rxPauseActive);

endmodule

// File: tb/pause_flow_trigger_tb.sv
module pause_flow_trigger_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic [4:0] freeKb = 5'd16;
  logic txReq;
  logic [15:0] txPauseTime;
  logic txDone = 0, rxPauseValid = 0, rxPauseActive = 0;
  logic txHalt;
  logic halfDuplex = 0, rxPktStart = 0, rxDaMatch = 0;
  logic jamReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pause_flow_trigger dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .freeKb(freeKb), .txReq(txReq), .txPauseTime(txPauseTime),
    .txDone(txDone), .rxPauseValid(rxPauseValid),
    .rxPauseActive(rxPauseActive), .txHalt(txHalt),
    .halfDuplex(halfDuplex), .rxPktStart(rxPktStart),
    .rxDaMatch(rxDaMatch), .jamReq(jamReq)
  );

  // {freeKb, txDone, expected txReq, expected txPauseTime}
  localparam logic [22:0] VEC [11] = '{
    {5'd16, 1'b0, 1'b0, 16'h0000},  // R4 no release without prior pause
    {5'd10, 1'b0, 1'b0, 16'h0000},  // R4
    {5'd2,  1'b0, 1'b1, 16'hFFFF},  // R2 crossing below high mark
    {5'd2,  1'b0, 1'b1, 16'hFFFF},  // R8 held until done
    {5'd5,  1'b1, 1'b0, 16'hFFFF},  // R5 armed, not yet above low
    {5'd2,  1'b0, 1'b0, 16'hFFFF},  // R5 no repeat while armed
    {5'd9,  1'b0, 1'b1, 16'h0000},  // R4 release above low
    {5'd9,  1'b1, 1'b0, 16'h0000},  // R5 back to idle
    {5'd2,  1'b0, 1'b1, 16'hFFFF},  // R5 fresh crossing
    {5'd12, 1'b1, 1'b1, 16'h0000},  // R4 release right after done
    {5'd12, 1'b1, 1'b0, 16'h0000}   // R5 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    step();
    regWrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    step();
    regRdEn = 0;
  endtask

  task automatic ackNow();
    txDone = 1;
    step();
    txDone = 0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
        finishRun();
      end
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 thr", d, 8'h38);
    rd(2'd1, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd2, d); chk("R1 bp", d, 8'h0C);
    chk("R1 txReq", txReq, 0);
    chk("R1 jamReq", jamReq, 0);

    // table walk: automatic hysteresis with default marks
    wr(2'd1, 8'h04);
    foreach (VEC[i]) begin
      freeKb = VEC[i][22:18];
      txDone = VEC[i][17];
      step();
      txDone = 0;
      step();
      chk($sformatf("R2/R4/R5 vec%0d req", i), txReq, VEC[i][16]);
      if (VEC[i][16]) chk($sformatf("R2/R4 vec%0d time", i), txPauseTime, VEC[i][15:0]);
    end

    // R3 zero high mark
    wr(2'd0, 8'h08);
    freeKb = 5'd1; step(); step(); step();
    chk("R3 no fire at 1KB", txReq, 0);
    freeKb = 5'd0; step(); step();
    chk("R3 fire at empty", txReq, 1);
    chk("R3 time", txPauseTime, 16'hFFFF);
    ackNow();
    freeKb = 5'd12; step(); step();
    chk("R3 release", txPauseTime, 16'h0000);
    ackNow();
    wr(2'd0, 8'h38);

    // R6 automatic disabled
    wr(2'd1, 8'h00);
    freeKb = 5'd1; step(); step(); step();
    chk("R6 no request", txReq, 0);
    freeKb = 5'd12; step();

    // R7 manual commands
    wr(2'd1, 8'h01); step();
    chk("R7 xon req", txReq, 1);
    chk("R7 xon time", txPauseTime, 16'h0000);
    rd(2'd1, d); chk("R7 bit0 pending", d, 8'h01);
    ackNow(); step();
    rd(2'd1, d); chk("R7 bit0 cleared", d, 8'h00);
    chk("R7 single request", txReq, 0);
    wr(2'd1, 8'h02); step();
    chk("R7 xoff time", txPauseTime, 16'hFFFF);
    ackNow(); step();
    rd(2'd1, d); chk("R7 bit1 cleared", d, 8'h00);

    // R8 manual and automatic pending together
    wr(2'd1, 8'h04);
    regWrEn = 1; regAddr = 2'd1; regWrData = 8'h05; freeKb = 5'd1;
    step();
    regWrEn = 0;
    step();
    chk("R8 manual first", txPauseTime, 16'h0000);
    chk("R8 req up", txReq, 1);
    step(); step();
    chk("R8 still held", txReq, 1);
    chk("R8 time stable", txPauseTime, 16'h0000);
    ackNow(); step();
    chk("R8 auto follows", txReq, 1);
    chk("R8 auto time", txPauseTime, 16'hFFFF);
    ackNow();
    wr(2'd1, 8'h00);

    // R9 received pause status
    rxPauseValid = 1; step(); rxPauseValid = 0;
    rd(2'd1, d); chk("R9 seen set", d, 8'h40);
    rd(2'd1, d); chk("R9 read clears", d, 8'h00);
    regRdEn = 1; regAddr = 2'd1; rxPauseValid = 1;
    step();
    regRdEn = 0; rxPauseValid = 0;
    rd(2'd1, d); chk("R9 pulse beats clear", d, 8'h40);
    rxPauseActive = 1; #1;
    rd(2'd1, d); chk("R9 current state", d, 8'h80);

    // R10 halt gating
    chk("R10 disabled", txHalt, 0);
    wr(2'd1, 8'h08);
    chk("R10 enabled", txHalt, 1);
    rxPauseActive = 0; #1;
    chk("R10 no pause", txHalt, 0);

    // R11 back-pressure jam
    wr(2'd2, 8'h0A);
    freeKb = 5'd4; halfDuplex = 1;
    wr(2'd1, 8'h10);
    rxPktStart = 1; step(); rxPktStart = 0;
    chk("R11 any jam", jamReq, 1);
    step();
    chk("R11 one cycle", jamReq, 0);
    freeKb = 5'd8;
    rxPktStart = 1; step(); rxPktStart = 0;
    chk("R11 below threshold", jamReq, 0);
    freeKb = 5'd4;
    wr(2'd1, 8'h20);
    rxPktStart = 1; rxDaMatch = 0; step(); rxPktStart = 0;
    chk("R11 no match", jamReq, 0);
    rxPktStart = 1; rxDaMatch = 1; step(); rxPktStart = 0;
    chk("R11 match jam", jamReq, 1);
    halfDuplex = 0;
    rxPktStart = 1; step(); rxPktStart = 0;
    chk("R11 full duplex", jamReq, 0);

    finishRun();
  end

endmodule